// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner folds many level-sensitive interrupt sources into a smaller set of output lines for a parent interrupt controller. Sources are gathered eight to a group, and every group drives one registered output that is the OR of its active, enabled sources. When a group line rises, software reads a status word to see which of the eight sources caused it.

Registers are 32 bits wide. Four groups are packed into each register bank, one byte lane per group: group n sits in lane n mod 4 of bank n/4, and banks are spaced 0x10 bytes apart. Enables change only through two write-one registers, one that sets bits and one that clears them. A bit written as zero changes nothing, so one group's enables can be changed without a read-modify-write that might disturb another group. The number of groups is a parameter and must be a multiple of four.

Top module: `irq_group_combiner`

## Requirements
- R1: While `rst` is high at a clock edge, every enable bit clears to 0, and `grp_irq` and `bus_rdata` go to 0 at that edge.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1 and leaves the enable bits written as 0 unchanged.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1 and leaves the enable bits written as 0 unchanged.
- R4: Group n uses bits [8*(n mod 4)+7 : 8*(n mod 4)] of the bank at byte address (n/4)*0x10. Source k of a group is bit k of its byte lane.
- R5: A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled high. Offsets 0x0 and 0x4 return the bank's current enable word. Offset 0xC returns the source levels ANDed with the enable bits. In every cycle after a clock edge with no read, `bus_rdata` is 0.
- R6: `grp_irq[n]` is the OR of group n's sources ANDed with its enables, as sampled at the previous clock edge. An enable write therefore affects the line one cycle after the write edge.
- R7: Writes to offset 0x8, to offsets that are not one of the three registers, or to banks beyond the last one change no enable bit. Reads of them return 0.
- R8: Sources are level sensitive and nothing is latched. When an enabled source drops, its group line falls one cycle later unless another enabled source in the group is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_GROUPS*8 | Level-sensitive sources; group n on bits [8n+7:8n] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address: bank in bits above 3, offset in bits [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| grp_irq | output | NUM_GROUPS | One combined interrupt line per group |

## Verification
The bench targets lane and bank placement: a wrong lane shift or bank stride would enable the wrong group, and the wrong `grp_irq` bit would rise. It checks that zero bits in set and clear writes have no effect, which catches a design that overwrites the enable word instead of masking it. Writes to the hole at 0x8, to unaligned offsets and to banks past the end are followed by reads of the real enables, so an incomplete decode that aliases them shows up as corrupted state. Sources are also dropped while enabled, so a design that latched them would hold its line high when it should fall.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

    localparam int LANES       = 4;
    localparam int SRC_PER_GRP = 8;
    localparam int WORD_W      = LANES * SRC_PER_GRP;
    localparam int OFS_W       = 4;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                   set_we;
        logic                   clr_we;
        logic [SRC_PER_GRP-1:0] bits;
    } grp_wr_s;

    function automatic reg_sel_e offset_to_sel(input logic [OFS_W-1:0] ofs);
        case (ofs)
            4'h0:    return REG_EN_SET;
            4'h4:    return REG_EN_CLR;
            4'hC:    return REG_STATUS;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_comb_regdec.sv
module irq_comb_regdec
    import irq_comb_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output reg_sel_e             sel,
    output logic [NUM_BANKS-1:0] bank_hit
);
    localparam int BANK_W = ADDR_W - OFS_W;

    logic [BANK_W-1:0] bank_field;

    assign bank_field = addr[ADDR_W-1:OFS_W];
    assign sel        = offset_to_sel(addr[OFS_W-1:0]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = (bank_field == BANK_W'(b));
    end

endmodule

// File: rtl/irq_comb_group.sv
module irq_comb_group
    import irq_comb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SRC_PER_GRP-1:0] src,
    input  grp_wr_s                wr,
    output logic [SRC_PER_GRP-1:0] en,
    output logic [SRC_PER_GRP-1:0] status,
    output logic                   irq
);
    always_ff @(posedge clk) begin
        if (rst)            en <= '0;
        else if (wr.set_we) en <= en | wr.bits;
        else if (wr.clr_we) en <= en & ~wr.bits;
    end

    assign status = src & en;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |status;
    end

    // R1: reset leaves every source disabled
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> (en == '0));

    // R2: written ones become enabled
    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
        wr.set_we |=> ((en & $past(wr.bits)) == $past(wr.bits)));

    // R2: zero bits of a set write keep their old value
    p_set_zero_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        wr.set_we |=> ((en & ~$past(wr.bits)) == ($past(en) & ~$past(wr.bits))));

    // R3: written ones become disabled, others unchanged
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (wr.clr_we && !wr.set_we) |=> (((en & $past(wr.bits)) == '0) &&
        ((en & ~$past(wr.bits)) == ($past(en) & ~$past(wr.bits)))));

    // R7: without a write strobe the enables stay put
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr.set_we && !wr.clr_we) |=> $stable(en));

    // R6: output line follows the enabled sources one cycle later
    p_line_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(src) & $past(en))));

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] src_in,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [WORD_W-1:0]                 bus_wdata,
    output logic [WORD_W-1:0]                 bus_rdata,
    output logic [NUM_GROUPS-1:0]             grp_irq
);
    localparam int NUM_BANKS = NUM_GROUPS / LANES;
    localparam int NUM_SRC   = NUM_GROUPS * SRC_PER_GRP;

    reg_sel_e             sel;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_SRC-1:0]   en_all;
    logic [NUM_SRC-1:0]   stat_all;
    logic [WORD_W-1:0]    rd_word;

    irq_comb_regdec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr     (bus_addr),
        .sel      (sel),
        .bank_hit (bank_hit)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        grp_wr_s wr;
        assign wr.set_we = bus_wr && (sel == REG_EN_SET) && bank_hit[g / LANES];
        assign wr.clr_we = bus_wr && (sel == REG_EN_CLR) && bank_hit[g / LANES];
        assign wr.bits   = bus_wdata[(g % LANES)*SRC_PER_GRP +: SRC_PER_GRP];

        irq_comb_group u_grp (
            .clk    (clk),
            .rst    (rst),
            .src    (src_in[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .wr     (wr),
            .en     (en_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .status (stat_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .irq    (grp_irq[g])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                case (sel)
                    REG_EN_SET, REG_EN_CLR: rd_word = en_all[b*WORD_W +: WORD_W];
                    REG_STATUS:             rd_word = stat_all[b*WORD_W +: WORD_W];
                    default:                rd_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

    // R5: idle cycles drive zero read data
    p_idle_rdata_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

    // R7: reads outside the register set return zero
    p_hole_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ((sel == REG_NONE) || (bank_hit == '0))) |=> (bus_rdata == '0));

    // R1: outputs quiet after reset
    p_reset_outputs_r1: assert property (@(posedge clk)
        rst |=> ((grp_irq == '0) && (bus_rdata == '0)));

endmodule

// File: tb/irq_group_combiner_tb.sv
module irq_group_combiner_tb;
    localparam int NG  = 8;
    localparam int NS  = NG * 8;
    localparam int NB  = NG / 4;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_in = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NG-1:0] grp_irq;

    always #10 clk = ~clk;

    irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_irq(grp_irq)
    );

    int    vectors = 0;
    int    fails   = 0;
    bit    started = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [NS-1:0] m_en;
    logic [31:0]   m_rd;
    logic [NG-1:0] m_irq;
    logic [NS-1:0] nxt_en;

    function automatic logic [31:0] ref_read(input logic [AW-1:0] a,
                                              input logic [NS-1:0] en,
                                              input logic [NS-1:0] s);
        int bank = int'(a) / 16;
        int ofs  = int'(a) % 16;
        if (bank >= NB) return 32'h0;
        if (ofs == 0 || ofs == 4) return en[bank*32 +: 32];
        if (ofs == 12) return (s & en) >> (bank*32);
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en  <= '0;
            m_rd  <= '0;
            m_irq <= '0;
        end else begin
            m_rd <= bus_rd ? ref_read(bus_addr, m_en, src_in) : 32'h0;
            for (int g = 0; g < NG; g++)
                m_irq[g] <= |(src_in[g*8 +: 8] & m_en[g*8 +: 8]);
            nxt_en = m_en;
            if (bus_wr && (int'(bus_addr) / 16) < NB) begin
                if (int'(bus_addr) % 16 == 0)
                    nxt_en[(int'(bus_addr)/16)*32 +: 32] = nxt_en[(int'(bus_addr)/16)*32 +: 32] | bus_wdata;
                else if (int'(bus_addr) % 16 == 4)
                    nxt_en[(int'(bus_addr)/16)*32 +: 32] = nxt_en[(int'(bus_addr)/16)*32 +: 32] & ~bus_wdata;
            end
            m_en <= nxt_en;
        end
        started <= 1'b1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (grp_irq !== m_irq) begin
                fails++;
                $display("FAIL %s grp_irq act=%h exp=%h", cur_req, grp_irq, m_irq);
            end
            vectors++;
            if (bus_rdata !== m_rd) begin
                fails++;
                $display("FAIL %s bus_rdata act=%h exp=%h", cur_req, bus_rdata, m_rd);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s directed act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        src_in = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {24'h0, grp_irq}, 32'h0);
        rd(8'h00); check("R1", bus_rdata, 32'h0);
        rd(8'h1C); check("R1", bus_rdata, 32'h0);

        // R2: set write, zero bits untouched
        cur_req = "R2";
        wr(8'h00, 32'h0000_00A5);
        rd(8'h00); check("R2", bus_rdata, 32'h0000_00A5);
        wr(8'h00, 32'h0000_0003);
        rd(8'h00); check("R2", bus_rdata, 32'h0000_00A7);

        // R3: clear write
        cur_req = "R3";
        wr(8'h04, 32'h0000_0021);
        rd(8'h04); check("R3", bus_rdata, 32'h0000_0086);

        // R4: lane and bank placement (group 6 = bank 1 lane 2)
        cur_req = "R4";
        wr(8'h10, 32'h00FF_0000);
        rd(8'h14); check("R4", bus_rdata, 32'h00FF_0000);
        @(negedge clk);
        check("R4", {24'h0, grp_irq}, 32'h0000_0041);

        // R5: status is levels ANDed with enables
        cur_req = "R5";
        src_in = '0;
        src_in[2]  = 1'b1; src_in[3] = 1'b1;
        src_in[50] = 1'b1; src_in[60] = 1'b1;
        rd(8'h0C); check("R5", bus_rdata, 32'h0000_0004);
        rd(8'h1C); check("R5", bus_rdata, 32'h0004_0000);
        @(negedge clk);
        check("R5", bus_rdata, 32'h0);

        // R7: holes and out-of-range banks
        cur_req = "R7";
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h08); check("R7", bus_rdata, 32'h0);
        rd(8'h2C); check("R7", bus_rdata, 32'h0);
        rd(8'h00); check("R7", bus_rdata, 32'h0000_0086);
        rd(8'h10); check("R7", bus_rdata, 32'h00FF_0000);

        // R8: level drop removes the line, no latching
        cur_req = "R8";
        src_in = '0;
        src_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        check("R8", {24'h0, grp_irq}, 32'h0000_0001);
        src_in[1] = 1'b0;
        @(negedge clk);
        check("R8", {24'h0, grp_irq}, 32'h0);

        // R6: random traffic against the model every clock
        cur_req = "R6";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            src_in = {$urandom, $urandom};
            bus_wr = 1'b0; bus_rd = 1'b0;
            case ($urandom % 4)
                0: begin bus_wr = 1'b1; bus_addr = AW'($urandom % 48); bus_wdata = $urandom; end
                1: begin bus_rd = 1'b1; bus_addr = AW'($urandom % 48); end
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule